// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor whose bus runs in its expanded mode. The processor reports the kind of each bus cycle on three status lines. The block turns that code into separate command strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces the controls for an external address latch and a bidirectional data transceiver:

- `ale` is the address latch enable.
- `den` is the data enable. It drives the transceiver's output enable.
- `dtR` is the direction. It drives the transceiver's transmit input.

Two write strobes are available for each write target:

- **Advanced write strobe.** It starts on the same clock as a read strobe, before write data is valid.
- **Normal write strobe.** It starts `WR_LAG` clocks later, so data is already valid at its leading edge.

The system uses whichever of the two the attached memory or peripheral needs.

A cycle starts when the status leaves the idle ("passive") code. It ends when the status returns to passive. Every output is a registered signal that is high when active.

Top module: `stat_cmd_ctrl`

## Requirements
- R1: While `rstN` is low, and at the first sample after reset, every command output, `ale` and `den` are 0, and `dtR` is 0 (receive).
- R2: Status codes are `000` interrupt acknowledge, `001` I/O read, `010` I/O write, `011` halt, `100` code fetch, `101` memory read, `110` memory write and `111` passive. At the clock edge that first samples a non-passive code after a passive one, `ale` rises for exactly one clock.
- R3: One clock after `ale` rises, the read-type strobe for the captured code asserts: `memRdCmd` for `100` or `101`, `ioRdCmd` for `001`, `intaCmd` for `000`.
- R4: For a write code (`110` memory, `010` I/O), the matching advanced write strobe (`memWrAdvCmd` or `ioWrAdvCmd`) asserts on the same clock a read strobe would.
- R5: The normal write strobe (`memWrCmd` or `ioWrCmd`) asserts `WR_LAG` clocks after its advanced strobe (one clock by default), and it stays off until then.
- R6: A halt cycle (`011`) and a passive status produce no command strobe and no `den`. Halt still pulses `ale`.
- R7: Every command strobe drops at the edge that first samples passive after a cycle, and at most one of the five normal-timing commands is ever active at a time.
- R8: `den` asserts together with the first strobe of a non-halt cycle, stays high while any strobe is active, and releases one clock after the strobes drop.
- R9: `dtR` is 1 (transmit) for write cycles from the `ale` clock until `den` releases. It is 0 (receive) for read, fetch, acknowledge and halt cycles and while idle, and it does not change while `den` stays high.
- R10: A new cycle may start after a single passive clock. Its `ale` pulse then coincides with the previous cycle's `den` release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| statusIn | input | 3 | Cycle-type status code from the processor |
| ale | output | 1 | Address latch enable, one-clock pulse per cycle |
| den | output | 1 | Transceiver output enable |
| dtR | output | 1 | Transceiver direction, 1 transmit, 0 receive |
| memRdCmd | output | 1 | Memory read command (code fetch or data read) |
| memWrCmd | output | 1 | Memory write command, normal timing |
| memWrAdvCmd | output | 1 | Memory write command, advanced timing |
| ioRdCmd | output | 1 | I/O read command |
| ioWrCmd | output | 1 | I/O write command, normal timing |
| ioWrAdvCmd | output | 1 | I/O write command, advanced timing |
| intaCmd | output | 1 | Interrupt acknowledge command |

## Verification
The assertions assume the processor drives the status in the usual way:

- Once the status leaves passive, it holds one non-passive code for at least two plus `WR_LAG` clocks.
- It never jumps straight from one non-passive code to another.
- At least one passive clock separates successive cycles.

The bench keeps within these rules by building every cycle from a single code, an active length of three to six clocks and a passive gap of one to three clocks. Both the random draws and the directed cases obey them, and the directed cases include the shortest legal cycle and back-to-back cycles with a one-clock gap.

// File: rtl/stat_cmd_pkg.sv
package stat_cmd_pkg;

  localparam int STAT_W = 3;
  localparam int CMD_N  = 5;
  localparam int ADV_N  = 2;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_CODE    = 3'b100,
    ST_MEMRD   = 3'b101,
    ST_MEMWR   = 3'b110,
    ST_PASSIVE = 3'b111
  } statCode_e;

  // slot numbers of the normal-timing command vector
  localparam int CMD_MEMRD = 0;
  localparam int CMD_MEMWR = 1;
  localparam int CMD_IORD  = 2;
  localparam int CMD_IOWR  = 3;
  localparam int CMD_INTA  = 4;

  // strobes from the sequencer to the output registers
  typedef struct packed {
    logic capture;  // latch cycle type, pulse ale, set direction
    logic issue;    // raise read-type and advanced strobes, den
    logic late;     // raise normal-timing write strobes
    logic drop;     // clear every command strobe
    logic relDen;   // release den and return direction to receive
  } ctlStrobe_t;

  function automatic logic isWrIdx(input int idx);
    return (idx == CMD_MEMWR) || (idx == CMD_IOWR);
  endfunction

  function automatic logic isWrStat(input logic [STAT_W-1:0] st);
    return (st == ST_MEMWR) || (st == ST_IOWR);
  endfunction

  function automatic int advToCmd(input int j);
    return (j == 0) ? CMD_MEMWR : CMD_IOWR;
  endfunction

  function automatic logic cmdHit(input logic [STAT_W-1:0] st, input int idx);
    logic hit;
    case (idx)
      CMD_MEMRD: hit = (st == ST_MEMRD) || (st == ST_CODE);
      CMD_MEMWR: hit = (st == ST_MEMWR);
      CMD_IORD:  hit = (st == ST_IORD);
      CMD_IOWR:  hit = (st == ST_IOWR);
      CMD_INTA:  hit = (st == ST_INTA);
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/stat_cmd_fsm.sv
module stat_cmd_fsm
  import stat_cmd_pkg::*;
#(
  parameter int WR_LAG = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  output ctlStrobe_t        strobe
);

  localparam int LAG_W = (WR_LAG < 1) ? 1 : $clog2(WR_LAG + 1);
  localparam logic [LAG_W-1:0] LAG_FIRE = LAG_W'(WR_LAG - 1);
  localparam logic [LAG_W-1:0] LAG_TOP  = LAG_W'(WR_LAG);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_CMD, S_REL} fsm_e;

  fsm_e             state, nextState;
  logic [LAG_W-1:0] lagCnt;
  logic             busy;

  assign busy = (statusIn != ST_PASSIVE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (busy) begin
          strobe.capture = 1'b1;
          nextState      = S_ADDR;
        end
      end
      S_ADDR: begin
        if (!busy) begin
          strobe.relDen = 1'b1;
          nextState     = S_IDLE;
        end else begin
          strobe.issue = 1'b1;
          nextState    = S_CMD;
        end
      end
      S_CMD: begin
        if (!busy) begin
          strobe.drop = 1'b1;
          nextState   = S_REL;
        end else if (lagCnt == LAG_FIRE) begin
          strobe.late = 1'b1;
        end
      end
      S_REL: begin
        strobe.relDen = 1'b1;
        if (busy) begin
          strobe.capture = 1'b1;
          nextState      = S_ADDR;
        end else begin
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      lagCnt <= '0;
    end else begin
      state <= nextState;
      if (strobe.issue) begin
        lagCnt <= '0;
      end else if (state == S_CMD && lagCnt != LAG_TOP) begin
        lagCnt <= lagCnt + 1'b1;
      end
    end
  end

  AST_LATE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.late |=> !strobe.late) else $error("late strobe repeated"); // R5

  AST_START_FROM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture) else $error("back-to-back capture"); // R2

endmodule

// File: rtl/stat_cmd_dp.sv
module stat_cmd_dp
  import stat_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  input  ctlStrobe_t        strobe,
  output logic              aleOut,
  output logic              denOut,
  output logic              dirOut,
  output logic [CMD_N-1:0]  cmdOut,
  output logic [ADV_N-1:0]  advOut
);

  logic [STAT_W-1:0] typeReg;
  logic              anyCmd;
  logic              earlyAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeReg <= ST_PASSIVE;
      aleOut  <= 1'b0;
      dirOut  <= 1'b0;
      denOut  <= 1'b0;
    end else begin
      aleOut <= strobe.capture;
      if (strobe.capture) begin
        typeReg <= statusIn;
        dirOut  <= isWrStat(statusIn);
      end else if (strobe.relDen) begin
        dirOut <= 1'b0;
      end
      if (strobe.relDen) begin
        denOut <= 1'b0;
      end else if (strobe.issue) begin
        denOut <= (typeReg != ST_HALT);
      end
    end
  end

  for (genvar g = 0; g < CMD_N; g++) begin : gCmd
    localparam bit WR_SLOT = isWrIdx(g);
    logic setNow;
    assign setNow = WR_SLOT ? strobe.late : strobe.issue;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdOut[g] <= 1'b0;
      end else if (strobe.drop) begin
        cmdOut[g] <= 1'b0;
      end else if (setNow) begin
        cmdOut[g] <= cmdHit(typeReg, g);
      end
    end
  end

  for (genvar j = 0; j < ADV_N; j++) begin : gAdv
    localparam int CI = advToCmd(j);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        advOut[j] <= 1'b0;
      end else if (strobe.drop) begin
        advOut[j] <= 1'b0;
      end else if (strobe.issue) begin
        advOut[j] <= cmdHit(typeReg, CI);
      end
    end

    AST_NORMAL_AFTER_ADV: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cmdOut[CI]) |-> $past(advOut[j])) else $error("normal write before advanced"); // R5
  end

  assign anyCmd   = (|cmdOut) || (|advOut);
  assign earlyAny = cmdOut[CMD_MEMRD] || cmdOut[CMD_IORD] || cmdOut[CMD_INTA] || (|advOut);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> !aleOut) else $error("ale longer than one clock"); // R2

  AST_EARLY_AFTER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(earlyAny) |-> $past(aleOut)) else $error("strobe without preceding ale"); // R3

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdOut)) else $error("two commands at once"); // R7

  AST_DEN_WITH_CMD: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |-> denOut) else $error("command without den"); // R8

  AST_DEN_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyCmd) |-> denOut) else $error("den released with commands"); // R8

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (denOut && $past(denOut)) |-> $stable(dirOut)) else $error("direction moved under den"); // R9

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (typeReg == ST_HALT) |-> (!anyCmd && !denOut)) else $error("halt produced a command"); // R6

endmodule

// File: rtl/stat_cmd_ctrl.sv
module stat_cmd_ctrl
  import stat_cmd_pkg::*;
#(
  parameter int WR_LAG = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  output logic              ale,
  output logic              den,
  output logic              dtR,
  output logic              memRdCmd,
  output logic              memWrCmd,
  output logic              memWrAdvCmd,
  output logic              ioRdCmd,
  output logic              ioWrCmd,
  output logic              ioWrAdvCmd,
  output logic              intaCmd
);

  ctlStrobe_t       strobe;
  logic [CMD_N-1:0] cmdVec;
  logic [ADV_N-1:0] advVec;

  stat_cmd_fsm #(.WR_LAG(WR_LAG)) fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .statusIn (statusIn),
    .strobe   (strobe)
  );

  stat_cmd_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .statusIn (statusIn),
    .strobe   (strobe),
    .aleOut   (ale),
    .denOut   (den),
    .dirOut   (dtR),
    .cmdOut   (cmdVec),
    .advOut   (advVec)
  );

  assign memRdCmd    = cmdVec[CMD_MEMRD];
  assign memWrCmd    = cmdVec[CMD_MEMWR];
  assign ioRdCmd     = cmdVec[CMD_IORD];
  assign ioWrCmd     = cmdVec[CMD_IOWR];
  assign intaCmd     = cmdVec[CMD_INTA];
  assign memWrAdvCmd = advVec[0];
  assign ioWrAdvCmd  = advVec[1];

endmodule

// File: tb/stat_cmd_ctrl_tb.sv
module stat_cmd_ctrl_tb_top;

  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] statusIn = 3'b111;
  logic ale, den, dtR, memRdCmd, memWrCmd, memWrAdvCmd, ioRdCmd, ioWrCmd, ioWrAdvCmd, intaCmd;

  int checks = 0;
  int fails  = 0;
  int lastGap = 0;

  always #(CLK_P/2) clk = ~clk;

  stat_cmd_ctrl dut_i (
    .clk(clk), .rstN(rstN), .statusIn(statusIn),
    .ale(ale), .den(den), .dtR(dtR),
    .memRdCmd(memRdCmd), .memWrCmd(memWrCmd), .memWrAdvCmd(memWrAdvCmd),
    .ioRdCmd(ioRdCmd), .ioWrCmd(ioWrCmd), .ioWrAdvCmd(ioWrAdvCmd), .intaCmd(intaCmd)
  );

  task automatic chk(input string tag, input string nm, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%0b exp=%0b", tag, nm, got, exp);
    end
  endtask

  // expected windows relative to the start edge (row 0) of a cycle of length len
  function automatic logic expEarly(input int i, input int len);
    return (i >= 1) && (i <= len - 1);
  endfunction
  function automatic logic expLate(input int i, input int len);
    return (i >= 2) && (i <= len - 1);
  endfunction
  function automatic logic isWr(input int t);
    return (t == 6) || (t == 2);
  endfunction

  task automatic checkAllZero(input string tag);
    chk(tag, "ale", ale, 1'b0);
    chk(tag, "den", den, 1'b0);
    chk(tag, "dtR", dtR, 1'b0);
    chk(tag, "memRd", memRdCmd, 1'b0);
    chk(tag, "memWr", memWrCmd, 1'b0);
    chk(tag, "memWrAdv", memWrAdvCmd, 1'b0);
    chk(tag, "ioRd", ioRdCmd, 1'b0);
    chk(tag, "ioWr", ioWrCmd, 1'b0);
    chk(tag, "ioWrAdv", ioWrAdvCmd, 1'b0);
    chk(tag, "inta", intaCmd, 1'b0);
  endtask

  // one bus cycle: status t for len edges, then passive for gap edges
  task automatic runTxn(input int t, input int len, input int gap);
    for (int i = 0; i < len + gap; i++) begin
      string cTag;
      string aTag;
      string dTag;
      logic  inWin;
      logic  lateWin;
      @(negedge clk);
      statusIn = (i < len) ? 3'(t) : 3'b111;
      @(posedge clk);
      #1;
      inWin   = expEarly(i, len);
      lateWin = expLate(i, len);
      cTag = (t == 3) ? "R6" : (i >= len) ? "R7" : "R3";
      aTag = (i == 0 && lastGap == 1) ? "R10" : "R2";
      dTag = (t == 3) ? "R6" : "R8";
      chk(aTag, "ale", ale, i == 0);
      chk(cTag, "memRd", memRdCmd, (t == 4 || t == 5) && inWin);
      chk(cTag, "ioRd", ioRdCmd, (t == 1) && inWin);
      chk(cTag, "inta", intaCmd, (t == 0) && inWin);
      chk((i >= len) ? "R7" : "R4", "memWrAdv", memWrAdvCmd, (t == 6) && inWin);
      chk((i >= len) ? "R7" : "R4", "ioWrAdv", ioWrAdvCmd, (t == 2) && inWin);
      chk((i >= len) ? "R7" : "R5", "memWr", memWrCmd, (t == 6) && lateWin);
      chk((i >= len) ? "R7" : "R5", "ioWr", ioWrCmd, (t == 2) && lateWin);
      chk((i == 0 && lastGap == 1) ? "R10" : dTag, "den", den, (t != 3) && i >= 1 && i <= len);
      chk("R9", "dtR", dtR, isWr(t) && i <= len);
    end
    lastGap = gap;
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int unsigned seedVal;
    seedVal = $urandom(32'h1F2E);
    rstN = 1'b0;
    statusIn = 3'b110;
    repeat (3) @(posedge clk);
    #1;
    checkAllZero("R1");
    @(negedge clk);
    statusIn = 3'b111;
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkAllZero("R1");

    // passive status alone does nothing
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      #1;
      checkAllZero("R6");
    end

    // every code once at the shortest legal length, one passive clock apart
    for (int t = 0; t < 7; t++) runTxn(t, 3, 1);
    // longer writes and reads with wider gaps
    runTxn(6, 6, 3);
    runTxn(2, 5, 2);
    runTxn(3, 5, 1);
    runTxn(5, 4, 1);
    runTxn(0, 3, 2);

    // constrained random traffic
    for (int n = 0; n < 300; n++) begin
      runTxn(int'($urandom % 7), 3 + int'($urandom % 4), 1 + int'($urandom % 3));
    end

    @(negedge clk);
    statusIn = 3'b111;
    @(posedge clk);
    #1;
    checkAllZero("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule